// File: doc/BRIEF.md
# Sixteen-Bit Processor ALU with Registered Status Flags

This block is the execute-stage arithmetic and logic unit of a small pipelined processor. It takes two operands and a 5-bit operation code. It returns the result combinationally in the same cycle. It also captures a 4-bit one-hot status vector in a register on the rising clock edge, so the pipeline stage that follows sees the status of the operation from the previous cycle.

The operation set has six parts: add and subtract with fused increment and decrement forms, single-bit shifts, all two-input logic functions including forms with an inverted operand, all-zero and all-one constants, operand pass-through, and byte-wise loads of a constant into either half of an operand. Only one status bit is set at a time. When several conditions hold together, a fixed priority decides which one is reported. Operation codes outside the map give a zero result and set the error status.

Top module: `alu16_core`

## Requirements
- R1: Arithmetic codes give a 16-bit result modulo 2^16: 00000 gives A+B, 00001 gives A+B+1, 00011 gives A+1, 00100 gives A-B-1, 00101 gives A-B, 00110 gives A-1.
- R2: Code 01000 shifts A left by one and fills bit 0 with zero. Code 01001 shifts A right by one and copies bit 15 into the vacated top bit.
- R3: Logic codes: 10001 gives A&B, 10010 gives ~A&B, 10100 gives A&~B, 10110 gives A^B, 10111 gives A|B, 11000 gives ~(A|B), 11001 gives ~(A^B), 11011 gives ~A|B, 11101 gives A|~B, 11110 gives ~(A&B).
- R4: Constant and pass codes: 10000 gives all zeros, 11111 gives all ones, 10011 gives B, 10101 gives A, 11010 gives ~A, 11100 gives ~B.
- R5: Code 00010 gives {A[15:8], B[7:0]}. Code 00111 gives {B[7:0], A[7:0]}.
- R6: The codes 01010 through 01111 are undefined. They give a result of zero and select the error status.
- R7: The status vector uses bit 0 for equal (A==B), bit 1 for above (A>B unsigned), bit 2 for overflow and bit 3 for error. At most one bit is set at any time.
- R8: Priority from highest to lowest is error, then overflow, then equal, then above. Only the highest-priority condition that holds is reported. If none holds, the vector is zero.
- R9: Overflow is reported only for the six arithmetic codes, and only when the exact signed result falls outside -32768..32767.
- R10: The status vector takes its new value on the rising clock edge after the operands and code are applied. A synchronous active-high reset clears it to zero. The result output does not depend on the clock.
- R11: For codes 00011 and 00110 the result does not depend on B. B still drives the equal and above conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the status register |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| opcode | input | 5 | Operation code |
| result | output | 16 | Combinational operation result |
| flags | output | 4 | Registered one-hot status vector |

## Verification
Overflow and operand equality can hold in the same cycle. Adding 0x4000 to itself, or incrementing 0x7FFF while B equals A, are two ways to produce this. The bench applies such vectors directly and expects only the overflow bit one edge later. Error and equality can also hold together when an undefined code is applied with equal operands, and the bench expects only the error bit in that case. Random vectors then mix all codes, undefined ones included, and each result and status value is compared with an independent model that computes overflow from the signed integer range.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int OPC_W  = 5;
    localparam int FLAG_W = 4;

    // bit positions of the one-hot status vector
    localparam int ST_EQ    = 0;
    localparam int ST_ABOVE = 1;
    localparam int ST_OVF   = 2;
    localparam int ST_ERR   = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD     = 5'b00000,
        OP_ADD_INC = 5'b00001,
        OP_LD_LO   = 5'b00010,
        OP_INC_A   = 5'b00011,
        OP_SUB_DEC = 5'b00100,
        OP_SUB     = 5'b00101,
        OP_DEC_A   = 5'b00110,
        OP_LD_HI   = 5'b00111,
        OP_SHL     = 5'b01000,
        OP_SAR     = 5'b01001,
        OP_ZERO    = 5'b10000,
        OP_AND     = 5'b10001,
        OP_NA_AND  = 5'b10010,
        OP_PASS_B  = 5'b10011,
        OP_AND_NB  = 5'b10100,
        OP_PASS_A  = 5'b10101,
        OP_XOR     = 5'b10110,
        OP_OR      = 5'b10111,
        OP_NOR     = 5'b11000,
        OP_XNOR    = 5'b11001,
        OP_NOT_A   = 5'b11010,
        OP_NA_OR   = 5'b11011,
        OP_NOT_B   = 5'b11100,
        OP_OR_NB   = 5'b11101,
        OP_NAND    = 5'b11110,
        OP_ONES    = 5'b11111
    } alu_op_e;

    // raw conditions handed to the status register
    typedef struct packed {
        logic err;
        logic ovf;
        logic eq;
        logic above;
    } alu_cond_t;

    function automatic logic op_is_arith(logic [OPC_W-1:0] c);
        return (c == OP_ADD) || (c == OP_ADD_INC) || (c == OP_INC_A) ||
               (c == OP_SUB_DEC) || (c == OP_SUB) || (c == OP_DEC_A);
    endfunction

    // the only holes in the map are 01010..01111
    function automatic logic op_is_known(logic [OPC_W-1:0] c);
        return !((c[4:3] == 2'b01) && (c[2:1] != 2'b00));
    endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OPC_W-1:0] opc,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] addend;
    logic             cin;

    // every arithmetic form is a + addend + cin
    always_comb begin
        addend = '0;
        cin    = 1'b0;
        case (opc)
            OP_ADD:     begin addend = b;          cin = 1'b0; end
            OP_ADD_INC: begin addend = b;          cin = 1'b1; end
            OP_INC_A:   begin addend = '0;         cin = 1'b1; end
            OP_SUB_DEC: begin addend = ~b;         cin = 1'b0; end
            OP_SUB:     begin addend = ~b;         cin = 1'b1; end
            OP_DEC_A:   begin addend = '1;         cin = 1'b0; end
            default:    begin addend = '0;         cin = 1'b0; end
        endcase
    end

    assign sum = a + addend + {{(WIDTH-1){1'b0}}, cin};

    // signed overflow: like-signed inputs produce an opposite-signed sum
    assign ovf = op_is_arith(opc) && (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OPC_W-1:0] opc,
    output logic [WIDTH-1:0] res
);

    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    always_comb begin
        case (opc)
            OP_SHL:    res = {a[MSB-1:0], 1'b0};
            OP_SAR:    res = {a[MSB], a[MSB:1]};
            OP_ZERO:   res = '0;
            OP_AND:    res = a & b;
            OP_NA_AND: res = ~a & b;
            OP_PASS_B: res = b;
            OP_AND_NB: res = a & ~b;
            OP_PASS_A: res = a;
            OP_XOR:    res = a ^ b;
            OP_OR:     res = a | b;
            OP_NOR:    res = ~(a | b);
            OP_XNOR:   res = ~(a ^ b);
            OP_NOT_A:  res = ~a;
            OP_NA_OR:  res = ~a | b;
            OP_NOT_B:  res = ~b;
            OP_OR_NB:  res = a | ~b;
            OP_NAND:   res = ~(a & b);
            OP_ONES:   res = '1;
            OP_LD_LO:  res = {a[MSB:HALF], b[HALF-1:0]};
            OP_LD_HI:  res = {b[HALF-1:0], a[HALF-1:0]};
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  alu_cond_t         cond,
    output logic [FLAG_W-1:0] flags_q
);

    logic [FLAG_W-1:0] flags_d;

    // fixed priority: error > overflow > equal > above
    always_comb begin
        flags_d = '0;
        if (cond.err)        flags_d[ST_ERR]   = 1'b1;
        else if (cond.ovf)   flags_d[ST_OVF]   = 1'b1;
        else if (cond.eq)    flags_d[ST_EQ]    = 1'b1;
        else if (cond.above) flags_d[ST_ABOVE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // R7
    onehot_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_q));

    // R8
    err_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cond.err |=> (flags_q == 4'b1000));

    // R8
    ovf_over_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (!cond.err && cond.ovf) |=> (flags_q == 4'b0100));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic [OPC_W-1:0]  opcode,
    output logic [WIDTH-1:0]  result,
    output logic [FLAG_W-1:0] flags
);

    logic [WIDTH-1:0] arith_sum;
    logic [WIDTH-1:0] misc_res;
    logic             arith_ovf;
    logic             is_arith;
    logic             is_known;
    alu_cond_t        cond;

    assign is_arith = op_is_arith(opcode);
    assign is_known = op_is_known(opcode);

    alu16_arith #(.WIDTH(WIDTH)) arith_i (
        .a   (opa),
        .b   (opb),
        .opc (opcode),
        .sum (arith_sum),
        .ovf (arith_ovf)
    );

    alu16_bitops #(.WIDTH(WIDTH)) bitops_i (
        .a   (opa),
        .b   (opb),
        .opc (opcode),
        .res (misc_res)
    );

    assign result = is_arith ? arith_sum : misc_res;

    always_comb begin
        cond.err   = !is_known;
        cond.ovf   = arith_ovf;
        cond.eq    = (opa == opb);
        cond.above = (opa > opb);
    end

    alu16_flagreg flag_i (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond),
        .flags_q (flags)
    );

    // R6
    bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !is_known |-> (result == '0));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !is_arith |=> !flags[ST_OVF]);

endmodule

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [4:0]  opcode = '0;
    logic [15:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core dut_i (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .opcode(opcode), .result(result), .flags(flags)
    );

    function automatic string req_of(logic [4:0] c);
        case (c)
            5'b00000, 5'b00001, 5'b00011,
            5'b00100, 5'b00101, 5'b00110: return "R1";
            5'b01000, 5'b01001:           return "R2";
            5'b10000, 5'b11111, 5'b10011,
            5'b10101, 5'b11010, 5'b11100: return "R4";
            5'b00010, 5'b00111:           return "R5";
            5'b01010, 5'b01011, 5'b01100,
            5'b01101, 5'b01110, 5'b01111: return "R6";
            default:                      return "R3";
        endcase
    endfunction

    // independent model: signed integer range gives overflow
    task automatic model(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic [3:0] f);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int v  = 0;
        bit ar = 1'b1;
        bit bad = 1'b0;
        r = '0;
        case (c)
            5'b00000: v = sa + sb;
            5'b00001: v = sa + sb + 1;
            5'b00011: v = sa + 1;
            5'b00100: v = sa - sb - 1;
            5'b00101: v = sa - sb;
            5'b00110: v = sa - 1;
            default:  ar = 1'b0;
        endcase
        if (ar) r = v[15:0];
        else begin
            case (c)
                5'b01000: r = {a[14:0], 1'b0};
                5'b01001: r = {a[15], a[15:1]};
                5'b10000: r = 16'h0000;
                5'b10001: r = a & b;
                5'b10010: r = ~a & b;
                5'b10011: r = b;
                5'b10100: r = a & ~b;
                5'b10101: r = a;
                5'b10110: r = a ^ b;
                5'b10111: r = a | b;
                5'b11000: r = ~(a | b);
                5'b11001: r = ~(a ^ b);
                5'b11010: r = ~a;
                5'b11011: r = ~a | b;
                5'b11100: r = ~b;
                5'b11101: r = a | ~b;
                5'b11110: r = ~(a & b);
                5'b11111: r = 16'hFFFF;
                5'b00010: r = {a[15:8], b[7:0]};
                5'b00111: r = {b[7:0], a[7:0]};
                default: begin r = 16'h0000; bad = 1'b1; end
            endcase
        end
        if (bad)                                   f = 4'b1000;
        else if (ar && (v > 32767 || v < -32768))  f = 4'b0100;
        else if (a == b)                           f = 4'b0001;
        else if (a > b)                            f = 4'b0010;
        else                                       f = 4'b0000;
    endtask

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic [4:0] c, logic [15:0] a, logic [15:0] b);
        logic [15:0] er;
        logic [3:0]  ef;
        @(negedge clk);
        opcode = c; opa = a; opb = b;
        model(c, a, b, er, ef);
        #1 check16(req_of(c), result, er);
        @(posedge clk);
        #1 check16((ef == 4'b1000) ? "R8/R6" : "R8", {12'h0, flags}, {12'h0, ef});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r1, r2;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #1 check16("R10 reset", {12'h0, flags}, 16'h0);
        @(negedge clk); rst = 1'b0;

        // directed corners
        apply(5'b00000, 16'h4000, 16'h4000);   // overflow beats equal
        apply(5'b00011, 16'h7FFF, 16'h7FFF);   // R9 inc overflow with equal
        apply(5'b00110, 16'h8000, 16'h0001);   // R9 dec overflow
        apply(5'b00101, 16'h8000, 16'h0001);   // sub overflow
        apply(5'b00100, 16'h0005, 16'h0003);   // A-B-1
        apply(5'b00001, 16'hFFFF, 16'h0000);   // wraps, no signed ovf
        apply(5'b01001, 16'h8002, 16'h0000);   // R2 sign fill
        apply(5'b01000, 16'h8001, 16'h8001);   // R2 shl, equal
        apply(5'b00010, 16'hABCD, 16'h1234);   // R5 low load
        apply(5'b00111, 16'hABCD, 16'h1234);   // R5 high load
        apply(5'b01100, 16'h5555, 16'h5555);   // R6 error beats equal
        apply(5'b01111, 16'h0001, 16'h0000);
        apply(5'b10111, 16'h0000, 16'h0000);   // R9 no ovf for logic
        apply(5'b11110, 16'h0003, 16'h0001);   // above

        // R11: B does not change an inc or dec result
        @(negedge clk); opcode = 5'b00011; opa = 16'h1234; opb = 16'h0000;
        #1 r1 = result;
        opb = 16'hFFFF;
        #1 r2 = result;
        check16("R11 inc", r2, r1);
        opcode = 5'b00110; opb = 16'h0000;
        #1 r1 = result;
        opb = 16'h8765;
        #1 check16("R11 dec", result, r1);

        // R10: synchronous reset clears a pending error status
        apply(5'b01010, 16'h0000, 16'h0001);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        #1 check16("R10 sync reset", {12'h0, flags}, 16'h0);
        @(negedge clk); rst = 1'b0;

        // every code once, then random mix
        for (int c = 0; c < 32; c++)
            apply(c[4:0], 16'h0F0F ^ 16'(c * 16'h1111), 16'h3C3C);
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = ($urandom % 8 == 0) ? a : 16'($urandom);
            apply(5'($urandom), a, b);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule